// File: doc/BRIEF.md
# Fused Multiply-Add NaN Selector

This block sits beside the datapath of a single-precision fused multiply-add unit computing (a*b)+c. For each operand triple it classifies a, b and c, detects a product of infinity and zero, and decides which operand, or a generated default NaN, should become the result. It also reports whether the invalid-operation flag must be raised. The arithmetic itself lives elsewhere. The datapath uses the result here only when `nan_case` is high.

Several machine conventions exist, so a 2-bit policy input selects the priority rules. A polarity input states whether a fraction MSB of one marks a signaling NaN (polarity 1) or a quiet NaN (polarity 0). Inputs are captured when `in_valid` is high, and the decision appears on the outputs one clock later. The outputs keep their value until the next valid input.

Top module: `fnan_select`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls with no valid input, every output is zero.
- R2: `out_valid` is high exactly one clock after a clock edge at which `in_valid` was high. The other outputs change only on such edges and otherwise hold their value.
- R3: An operand is a NaN when its 8-bit exponent (bits 30:23) is all ones and its 23-bit fraction (bits 22:0) is non-zero. Fraction bit 22 equal to the polarity input marks it signaling; otherwise it is quiet. An infinity-times-zero product means one of a, b has exponent all ones with a zero fraction and the other has exponent and fraction both zero, regardless of sign. `out_nan_case` is high when any operand is a NaN or the product is infinity times zero.
- R4: Under policy 0, an infinity-times-zero product with a quiet NaN c yields code 3. Otherwise the choice follows the order c signaling, a signaling, b signaling, c quiet, a quiet, else b. Codes are 0 = a, 1 = b, 2 = c, 3 = default NaN.
- R5: Under policy 1 with polarity 1, any infinity-times-zero product yields code 3. Otherwise signaling NaNs are chosen in the order a, b, c, then quiet NaNs in the order a, b, else c.
- R6: Under policy 1 with polarity 0, any infinity-times-zero product yields code 3. Otherwise the order is the one of R4.
- R7: Under policy 2, an infinity-times-zero product yields code 2. Otherwise the choice is a if a is any NaN, else c if c is any NaN, else b.
- R8: Under policy 3, the choice is a if a is any NaN, else b if b is any NaN, else c. Code 3 never occurs.
- R9: If the chosen operand is a signaling NaN, `out_val` is that operand with bit 22 set under polarity 0, and the default NaN under polarity 1. Any other chosen operand passes through unchanged.
- R10: Code 3 drives the default NaN on `out_val`: 0x7FC00000 under polarity 0 and 0x7FBFFFFF under polarity 1.
- R11: `out_invalid` is high when any operand is signaling. It is also high for an infinity-times-zero product under policy 1, under policy 2, or under policy 0 when c is a quiet NaN. It is low in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand triple present this cycle |
| op_a | input | 32 | Multiplicand a |
| op_b | input | 32 | Multiplier b |
| op_c | input | 32 | Addend c |
| policy | input | 2 | Priority policy select (0 to 3) |
| snan_pol | input | 1 | Value of fraction bit 22 that marks a signaling NaN |
| out_valid | output | 1 | Decision present this cycle |
| out_pick | output | 2 | Choice code: 0 a, 1 b, 2 c, 3 default NaN |
| out_val | output | 32 | Chosen value after quieting |
| out_invalid | output | 1 | Invalid-operation flag |
| out_nan_case | output | 1 | A NaN operand or infinity-times-zero product is present |

## Verification
The properties assume that `in_valid`, the operands, `policy` and `snan_pol` are settled before each rising edge. They carry no X values once reset has been released. The stimulus drives every input on the falling edge, which satisfies that assumption. The properties also assume that a NaN a never coincides with an infinity-times-zero product, and the encoding makes that impossible. The stimulus covers every ordered triple from a set of special values: both zeros, both infinities, normals, a subnormal, and NaNs with each state of bit 22 and each sign. Each triple is run under all policies and both polarities, with idle cycles mixed in, so holding of the outputs is exercised as well.

// File: rtl/fnan_pkg.sv
package fnan_pkg;

    typedef enum logic [1:0] {
        PICK_A    = 2'd0,
        PICK_B    = 2'd1,
        PICK_C    = 2'd2,
        PICK_DFLT = 2'd3
    } pick_e;

    typedef enum logic [1:0] {
        POL_C_FIRST  = 2'd0,
        POL_POLARITY = 2'd1,
        POL_A_THEN_C = 2'd2,
        POL_IN_ORDER = 2'd3
    } policy_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_qnan;
        logic is_inf;
        logic is_zero;
    } opclass_t;

    // Addend-first order shared by two policies: signaling c, a, b, then quiet c, a, else b.
    function automatic pick_e order_c_first(opclass_t ca, opclass_t cb, opclass_t cc);
        pick_e p;
        if (cc.is_snan)      p = PICK_C;
        else if (ca.is_snan) p = PICK_A;
        else if (cb.is_snan) p = PICK_B;
        else if (cc.is_qnan) p = PICK_C;
        else if (ca.is_qnan) p = PICK_A;
        else                 p = PICK_B;
        return p;
    endfunction

    // Signaling first in a, b, c order, then quiet a, b, else c.
    function automatic pick_e order_abc_snan(opclass_t ca, opclass_t cb, opclass_t cc);
        pick_e p;
        if (ca.is_snan)      p = PICK_A;
        else if (cb.is_snan) p = PICK_B;
        else if (cc.is_snan) p = PICK_C;
        else if (ca.is_qnan) p = PICK_A;
        else if (cb.is_qnan) p = PICK_B;
        else                 p = PICK_C;
        return p;
    endfunction

endpackage

// File: rtl/fnan_classify.sv
module fnan_classify
    import fnan_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W-1:0] mag,
    input  logic                   snan_pol,
    output opclass_t               cls
);
    localparam int MAG_W = EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_ones, exp_zero, man_zero, qbit;

    always_comb begin
        exp_f    = mag[MAG_W-1:MAN_W];
        man_f    = mag[MAN_W-1:0];
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;
        man_zero = ~|man_f;
        qbit     = man_f[MAN_W-1];
        cls.is_nan  = exp_ones & ~man_zero;
        cls.is_snan = exp_ones & ~man_zero & (qbit == snan_pol);
        cls.is_qnan = exp_ones & ~man_zero & (qbit != snan_pol);
        cls.is_inf  = exp_ones & man_zero;
        cls.is_zero = exp_zero & man_zero;
    end
endmodule

// File: rtl/fnan_priority.sv
module fnan_priority
    import fnan_pkg::*;
(
    input  opclass_t   ca,
    input  opclass_t   cb,
    input  opclass_t   cc,
    input  logic       infzero,
    input  logic [1:0] policy,
    input  logic       snan_pol,
    output pick_e      pick,
    output logic       ifz_invalid
);
    policy_e pol;

    always_comb begin
        pol         = policy_e'(policy);
        pick        = PICK_B;
        ifz_invalid = 1'b0;
        unique case (pol)
            POL_C_FIRST: begin
                if (infzero && cc.is_qnan) begin
                    pick        = PICK_DFLT;
                    ifz_invalid = 1'b1;
                end else begin
                    pick = order_c_first(ca, cb, cc);
                end
            end
            POL_POLARITY: begin
                if (infzero) begin
                    pick        = PICK_DFLT;
                    ifz_invalid = 1'b1;
                end else if (snan_pol) begin
                    pick = order_abc_snan(ca, cb, cc);
                end else begin
                    pick = order_c_first(ca, cb, cc);
                end
            end
            POL_A_THEN_C: begin
                if (infzero) begin
                    pick        = PICK_C;
                    ifz_invalid = 1'b1;
                end else if (ca.is_nan) begin
                    pick = PICK_A;
                end else if (cc.is_nan) begin
                    pick = PICK_C;
                end else begin
                    pick = PICK_B;
                end
            end
            POL_IN_ORDER: begin
                if (ca.is_nan)      pick = PICK_A;
                else if (cb.is_nan) pick = PICK_B;
                else                pick = PICK_C;
            end
            default: pick = PICK_B;
        endcase
    end
endmodule

// File: rtl/fnan_quiet.sv
module fnan_quiet
    import fnan_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  pick_e                    pick,
    input  logic [EXP_W+MAN_W:0]     op_a,
    input  logic [EXP_W+MAN_W:0]     op_b,
    input  logic [EXP_W+MAN_W:0]     op_c,
    input  logic [2:0]               snan_vec,
    input  logic                     snan_pol,
    output logic [EXP_W+MAN_W:0]     val
);
    localparam int DW = 1 + EXP_W + MAN_W;
    localparam logic [DW-1:0] DFLT_Q0 = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [DW-1:0] DFLT_Q1 = {1'b0, {EXP_W{1'b1}}, 1'b0, {(MAN_W-1){1'b1}}};
    localparam logic [DW-1:0] QUIET_BIT = DW'(1) << (MAN_W - 1);

    logic [DW-1:0] sel;
    logic [DW-1:0] dflt;
    logic          sel_snan;

    always_comb begin
        dflt = snan_pol ? DFLT_Q1 : DFLT_Q0;
        unique case (pick)
            PICK_A:  begin sel = op_a; sel_snan = snan_vec[0]; end
            PICK_B:  begin sel = op_b; sel_snan = snan_vec[1]; end
            PICK_C:  begin sel = op_c; sel_snan = snan_vec[2]; end
            default: begin sel = dflt; sel_snan = 1'b0;        end
        endcase
        if (pick == PICK_DFLT)   val = dflt;
        else if (!sel_snan)      val = sel;
        else if (snan_pol)       val = dflt;
        else                     val = sel | QUIET_BIT;
    end
endmodule

// File: rtl/fnan_select.sv
module fnan_select
    import fnan_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [EXP_W+MAN_W:0]     op_a,
    input  logic [EXP_W+MAN_W:0]     op_b,
    input  logic [EXP_W+MAN_W:0]     op_c,
    input  logic [1:0]               policy,
    input  logic                     snan_pol,
    output logic                     out_valid,
    output logic [1:0]               out_pick,
    output logic [EXP_W+MAN_W:0]     out_val,
    output logic                     out_invalid,
    output logic                     out_nan_case
);
    localparam int DW    = 1 + EXP_W + MAN_W;
    localparam int N_OPS = 3;

    logic [DW-1:0] ops [N_OPS];
    opclass_t      cls [N_OPS];
    logic [N_OPS-1:0] snan_vec, nan_vec;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign ops[2] = op_c;

    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        fnan_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .mag      (ops[i][DW-2:0]),
            .snan_pol (snan_pol),
            .cls      (cls[i])
        );
        assign snan_vec[i] = cls[i].is_snan;
        assign nan_vec[i]  = cls[i].is_nan;
    end

    logic  infzero;
    logic  ifz_invalid;
    pick_e pick_d;
    logic [DW-1:0] val_d;

    assign infzero = (cls[0].is_inf & cls[1].is_zero) | (cls[0].is_zero & cls[1].is_inf);

    fnan_priority u_pri (
        .ca          (cls[0]),
        .cb          (cls[1]),
        .cc          (cls[2]),
        .infzero     (infzero),
        .policy      (policy),
        .snan_pol    (snan_pol),
        .pick        (pick_d),
        .ifz_invalid (ifz_invalid)
    );

    fnan_quiet #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_qt (
        .pick     (pick_d),
        .op_a     (op_a),
        .op_b     (op_b),
        .op_c     (op_c),
        .snan_vec (snan_vec),
        .snan_pol (snan_pol),
        .val      (val_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_pick     <= 2'd0;
            out_val      <= '0;
            out_invalid  <= 1'b0;
            out_nan_case <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_pick     <= pick_d;
                out_val      <= val_d;
                out_invalid  <= (|snan_vec) | ifz_invalid;
                out_nan_case <= (|nan_vec) | infzero;
            end
        end
    end
endmodule

// File: rtl/fnan_select_chk.sv
module fnan_select_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [EXP_W+MAN_W:0] op_a,
    input logic [1:0]           policy,
    input logic                 out_valid,
    input logic [1:0]           out_pick,
    input logic [EXP_W+MAN_W:0] out_val,
    input logic                 out_invalid,
    input logic                 out_nan_case
);
    localparam int DW = 1 + EXP_W + MAN_W;

    logic a_nan;
    assign a_nan = (&op_a[DW-2:MAN_W]) && (|op_a[MAN_W-1:0]);

    p_vld_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_pick) && $stable(out_val)
                       && $stable(out_invalid) && $stable(out_nan_case)));

    p_nan_case_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && a_nan) |=> out_nan_case);

    p_a_first_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && policy == 2'd2 && a_nan) |=> out_pick == 2'd0);

    p_no_dflt_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && policy == 2'd3) |=> out_pick != 2'd3);

    p_dflt_nan_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_nan_case && out_pick == 2'd3)
            |-> ((&out_val[DW-2:MAN_W]) && (|out_val[MAN_W-1:0]) && !out_val[DW-1]));

    p_inv_case_r11: assert property (@(posedge clk) disable iff (rst)
        out_invalid |-> out_nan_case);
endmodule

bind fnan_select fnan_select_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .op_a         (op_a),
    .policy       (policy),
    .out_valid    (out_valid),
    .out_pick     (out_pick),
    .out_val      (out_val),
    .out_invalid  (out_invalid),
    .out_nan_case (out_nan_case)
);

// File: tb/sim_fnan_select.sv
module sim_fnan_select;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] op_a, op_b, op_c;
    logic [1:0]  policy;
    logic        snan_pol;
    logic        out_valid;
    logic [1:0]  out_pick;
    logic [31:0] out_val;
    logic        out_invalid;
    logic        out_nan_case;

    always #4 clk = ~clk;

    fnan_select u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .policy(policy), .snan_pol(snan_pol),
        .out_valid(out_valid), .out_pick(out_pick), .out_val(out_val),
        .out_invalid(out_invalid), .out_nan_case(out_nan_case)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // expected state (hold model)
    bit        e_valid = 0;
    int        e_pick  = 0;
    bit [31:0] e_val   = 0;
    bit        e_inv   = 0;
    bit        e_case  = 0;
    string     e_tag   = "R4";
    string     v_tag   = "R9";

    bit [31:0] specials [10] = '{32'h00000000, 32'h80000000, 32'h7F800000, 32'hFF800000,
                                 32'h3F800000, 32'h00000001, 32'h7FC00001, 32'h7F800005,
                                 32'hFFC12345, 32'h7FA00000};

    task automatic chk(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit f_nan(bit [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    // kind: 0 signaling, 1 quiet, 2 any NaN
    function automatic bit f_kind(bit [31:0] v, int kind, bit pol);
        if (!f_nan(v)) return 0;
        if (kind == 2) return 1;
        if (kind == 0) return v[22] == pol;
        return v[22] != pol;
    endfunction

    task automatic model(bit [31:0] a, bit [31:0] b, bit [31:0] c, int pol_sel, bit pol);
        bit [31:0] o [3];
        int  order [$];
        int  fallback;
        bit  ifz, any_s, any_n, inf_a, inf_b, z_a, z_b, forced;
        bit [31:0] dflt, chosen;
        o[0] = a; o[1] = b; o[2] = c;
        inf_a = (a[30:0] == 31'h7F800000); inf_b = (b[30:0] == 31'h7F800000);
        z_a   = (a[30:0] == 0);            z_b   = (b[30:0] == 0);
        ifz   = (inf_a && z_b) || (z_a && inf_b);
        any_s = 0; any_n = 0;
        foreach (o[i]) begin
            any_s |= f_kind(o[i], 0, pol);
            any_n |= f_nan(o[i]);
        end
        dflt   = pol ? 32'h7FBFFFFF : 32'h7FC00000;
        forced = 0;
        e_inv  = any_s;
        e_case = any_n || ifz;
        case (pol_sel)
            0: begin
                e_tag = "R4";
                if (ifz && f_kind(c, 1, pol)) begin forced = 1; e_pick = 3; e_inv = 1; end
                order = '{2*4+0, 0*4+0, 1*4+0, 2*4+1, 0*4+1}; fallback = 1;
            end
            1: begin
                e_tag = pol ? "R5" : "R6";
                if (ifz) begin forced = 1; e_pick = 3; e_inv = 1; end
                if (pol) begin order = '{0, 4, 8, 1, 5}; fallback = 2; end
                else begin order = '{8, 0, 4, 9, 1}; fallback = 1; end
            end
            2: begin
                e_tag = "R7";
                if (ifz) begin forced = 1; e_pick = 2; e_inv = 1; end
                order = '{0*4+2, 2*4+2}; fallback = 1;
            end
            default: begin
                e_tag = "R8";
                order = '{0*4+2, 1*4+2}; fallback = 2;
            end
        endcase
        if (!forced) begin
            e_pick = fallback;
            for (int k = order.size() - 1; k >= 0; k--)
                if (f_kind(o[order[k] / 4], order[k] % 4, pol)) e_pick = order[k] / 4;
        end
        if (e_pick == 3) begin
            e_val = dflt; v_tag = "R10";
        end else begin
            chosen = o[e_pick];
            if (f_kind(chosen, 0, pol)) begin
                v_tag = "R9";
                e_val = pol ? dflt : (chosen | 32'h00400000);
            end else begin
                v_tag = e_tag;
                e_val = chosen;
            end
        end
    endtask

    task automatic compare();
        chk("R2", "out_valid", out_valid, e_valid);
        if (e_valid) begin
            chk("R3", "out_nan_case", out_nan_case, e_case);
            chk("R11", "out_invalid", out_invalid, e_inv);
            if (e_case) begin
                chk(e_tag, "out_pick", out_pick, e_pick);
                chk(v_tag, "out_val", out_val, e_val);
            end
        end else begin
            chk("R2", "held out_pick", out_pick, e_pick);
            chk("R2", "held out_val", out_val, e_val);
        end
    endtask

    task automatic step(bit v, bit [31:0] a, bit [31:0] b, bit [31:0] c, int ps, bit pol);
        @(negedge clk);
        compare();
        in_valid = v; op_a = a; op_b = b; op_c = c; policy = 2'(ps); snan_pol = pol;
        e_valid = v;
        if (v) model(a, b, c, ps, pol);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1; in_valid = 0; op_a = 0; op_b = 0; op_c = 0; policy = 0; snan_pol = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "out_valid in reset", out_valid, 0);
        chk("R1", "out_val in reset", out_val, 0);
        rst = 0;
        @(negedge clk);
        chk("R1", "out_valid after reset", out_valid, 0);
        chk("R1", "out_pick after reset", out_pick, 0);
        chk("R1", "out_val after reset", out_val, 0);
        chk("R1", "out_invalid after reset", out_invalid, 0);
        chk("R1", "out_nan_case after reset", out_nan_case, 0);
        // directed corners: R4 inf*0 with quiet c, R7 inf*0 returns c, R9 quieting
        step(1, 32'h7F800000, 32'h00000000, 32'h7FC00001, 0, 0);
        step(1, 32'h80000000, 32'hFF800000, 32'h3F800000, 2, 0);
        step(1, 32'h3F800000, 32'h7F800005, 32'h3F800000, 3, 0);
        step(1, 32'h3F800000, 32'h7FC00001, 32'h3F800000, 1, 1);
        step(0, 0, 0, 0, 0, 0);
        for (int ps = 0; ps < 4; ps++)
            for (int pol = 0; pol < 2; pol++)
                for (int i = 0; i < 10; i++)
                    for (int j = 0; j < 10; j++)
                        for (int k = 0; k < 10; k++) begin
                            step(1, specials[i], specials[j], specials[k], ps, pol[0]);
                            if (((i + j + k) % 7) == 3) step(0, 32'hFFFFFFFF, 0, 0, ps, pol[0]);
                        end
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        finish_run();
    end
endmodule